// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a clocked system and an external 32K x 8 asynchronous static RAM. The system offers one read or one write at a time over a valid/ready handshake, with a write flag, a 15-bit word address and an 8-bit write value. Reads return their byte on `rd_data` together with a single-cycle `rd_valid` pulse. On the memory side the block drives active-low chip select, output enable and write enable, the address bus, and a shared data bus. The data bus is split into an outgoing value, an incoming value and a drive enable, so a pad ring or test model can resolve it.

The memory has no clock. Each of its nanosecond limits (read access, write pulse width, address and data setup to the end of the write, bus release after a read) becomes a clock-cycle count. The count is a ceiling division by the clock period parameter, and every phase lasts at least one cycle. A state machine with the states IDLE, RD_STROBE, RD_HOLD, RD_TURN, WR_SETUP, WR_PULSE and WR_HOLD walks through these phases, and one shared down-counter times them. The named transitions are as follows. IDLE moves to RD_STROBE or WR_SETUP on acceptance. RD_STROBE moves to RD_HOLD when the access count expires, which is also the capture edge. RD_HOLD moves to RD_TURN after one cycle. RD_TURN moves to IDLE when the bus-release count expires. WR_SETUP moves to WR_PULSE after one cycle. WR_PULSE moves to WR_HOLD when the pulse count expires. WR_HOLD moves to IDLE after one cycle.

With the default 20 ns clock these counts are 4 access cycles, 3 write-pulse cycles and 2 bus-release cycles.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `rd_valid` is 0 and `req_ready` is 1.
- R2: A request is accepted at a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance for RD_CYC+1+TURN_CYC cycles for a read (`req_write`=0) and for WE_CYC+2 cycles for a write (`req_write`=1). With the defaults these are 7 and 5 cycles.
- R3: A read drives `mem_cs_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for RD_CYC+1 cycles (5 by default), starting in the cycle after acceptance. During those cycles `mem_addr` equals the accepted address.
- R4: Read data is sampled from `mem_dq_in` at the edge that ends the RD_CYC-th strobe cycle. In the next cycle, while both strobes are still low, `rd_valid` is 1 for exactly one cycle and `rd_data` holds the sampled byte.
- R5: A write runs in three steps. First comes one setup cycle with all strobes 1, `mem_dq_oe`=1, and the address and data driven. Then `mem_cs_n` and `mem_we_n` are 0 for WE_CYC cycles (3 by default). Last comes one hold cycle with the strobes back at 1 and the address and data unchanged.
- R6: `mem_oe_n` is 1 whenever `mem_we_n` is 0 or `mem_dq_oe` is 1. Output enable and write enable are never low together.
- R7: `mem_dq_oe` is 0 while chip select and output enable are both low. It also stays 0 for at least TURN_CYC cycles after they are released.
- R8: Phase lengths are computed as max(1, ceil(ns / CLK_PERIOD_NS)). RD_CYC covers access from address, chip select and output enable. WE_CYC covers the write pulse width, data setup, address setup to write end less the setup cycle, and write cycle time less the setup and hold cycles. TURN_CYC covers the bus float time.
- R9: Changes on `req_valid`, `req_write`, `req_addr` and `req_wdata` while `req_ready` is 0 have no effect on the running transfer. Its address, data and direction are fixed at acceptance.
- R10: In IDLE with `req_valid`=0 no strobe goes low and `mem_dq_oe` stays 0, whatever the other request inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write value |
| rd_data | output | 8 | Captured read value |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` is new |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 15 | Memory address bus |
| mem_dq_out | output | 8 | Value driven onto the data bus |
| mem_dq_in | input | 8 | Value seen on the data bus |
| mem_dq_oe | output | 1 | Controller drives the data bus when 1 |

## Verification
Two things can coincide in one cycle. The bus-release wait after a read can expire just as a write request is already waiting. The bench provokes this by holding `req_valid` high through a read and switching the fields to a write as soon as the read is accepted. The write must then be taken in the first IDLE cycle. Its first driven cycle must fall exactly eight cycles after the read was accepted, and a bus model that keeps driving for a while after release must never see both sides driving. The same run checks that the earlier read still returns its own byte despite the request fields changing under it.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_STROBE,
        ST_RD_HOLD,
        ST_RD_TURN,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD
    } seq_state_t;

    // ceiling division of a time limit by the clock period, never below one cycle
    function automatic int ns_to_cycles(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/sram_bus_regs.sv
module sram_bus_regs #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    // address and write value are frozen at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    // read byte is sampled at the edge closing the access window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture) begin
                rd_data <= mem_dq_in;
            end
        end
    end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_strobe_pkg::*;
#(
    parameter int CNT_W    = 3,
    parameter int RD_CYC   = 4,
    parameter int WE_CYC   = 3,
    parameter int TURN_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             timer_done,
    output logic             req_ready,
    output logic             accept,
    output logic             capture,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             cs_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             dq_oe
);

    localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WE_LD   = CNT_W'(WE_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);

    seq_state_t state;
    seq_state_t nxt;

    assign accept  = (state == ST_IDLE) && req_valid;
    assign capture = (state == ST_RD_STROBE) && timer_done;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (req_valid) nxt = req_write ? ST_WR_SETUP : ST_RD_STROBE;
            ST_RD_STROBE: if (timer_done) nxt = ST_RD_HOLD;
            ST_RD_HOLD:   nxt = ST_RD_TURN;
            ST_RD_TURN:   if (timer_done) nxt = ST_IDLE;
            ST_WR_SETUP:  nxt = ST_WR_PULSE;
            ST_WR_PULSE:  if (timer_done) nxt = ST_WR_HOLD;
            ST_WR_HOLD:   nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // the shared timer is reloaded whenever a timed phase is entered
    always_comb begin
        tmr_load = (nxt != state);
        tmr_val  = '0;
        unique case (nxt)
            ST_RD_STROBE: tmr_val = RD_LD;
            ST_RD_TURN:   tmr_val = TURN_LD;
            ST_WR_PULSE:  tmr_val = WE_LD;
            default:      tmr_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // strobes come straight from flops, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n      <= 1'b1;
            oe_n      <= 1'b1;
            we_n      <= 1'b1;
            dq_oe     <= 1'b0;
            req_ready <= 1'b1;
        end else begin
            cs_n      <= 1'b1;
            oe_n      <= 1'b1;
            we_n      <= 1'b1;
            dq_oe     <= 1'b0;
            req_ready <= 1'b0;
            unique case (nxt)
                ST_IDLE: req_ready <= 1'b1;
                ST_RD_STROBE, ST_RD_HOLD: begin
                    cs_n <= 1'b0;
                    oe_n <= 1'b0;
                end
                ST_RD_TURN: ;
                ST_WR_SETUP, ST_WR_HOLD: dq_oe <= 1'b1;
                ST_WR_PULSE: begin
                    cs_n  <= 1'b0;
                    we_n  <= 1'b0;
                    dq_oe <= 1'b1;
                end
                default: req_ready <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_strobe_pkg::*;
#(
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_AA_NS       = 70,
    parameter int T_OE_NS       = 35,
    parameter int T_RC_NS       = 70,
    parameter int T_HZ_NS       = 25,
    parameter int T_PWE_NS      = 55,
    parameter int T_AW_NS       = 60,
    parameter int T_SD_NS       = 30,
    parameter int T_WC_NS       = 70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);

    localparam int RD_CYC = max2(max2(ns_to_cycles(T_AA_NS, CLK_PERIOD_NS),
                                      ns_to_cycles(T_OE_NS, CLK_PERIOD_NS)),
                                 ns_to_cycles(T_RC_NS, CLK_PERIOD_NS) - 1);
    localparam int WE_CYC = max2(max2(ns_to_cycles(T_PWE_NS, CLK_PERIOD_NS),
                                      ns_to_cycles(T_SD_NS, CLK_PERIOD_NS)),
                                 max2(ns_to_cycles(T_AW_NS, CLK_PERIOD_NS) - 1,
                                      ns_to_cycles(T_WC_NS, CLK_PERIOD_NS) - 2));
    localparam int TURN_CYC = ns_to_cycles(T_HZ_NS, CLK_PERIOD_NS);
    localparam int MAX_CYC  = max2(max2(RD_CYC, WE_CYC), TURN_CYC);
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    logic             accept;
    logic             capture;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;

    sram_seq_fsm #(
        .CNT_W    (CNT_W),
        .RD_CYC   (RD_CYC),
        .WE_CYC   (WE_CYC),
        .TURN_CYC (TURN_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .timer_done (tmr_done),
        .req_ready  (req_ready),
        .accept     (accept),
        .capture    (capture),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .cs_n       (mem_cs_n),
        .oe_n       (mem_oe_n),
        .we_n       (mem_we_n),
        .dq_oe      (mem_dq_oe)
    );

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_bus_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .capture    (capture),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

endmodule

// File: rtl/sram_strobe_chk.sv
module sram_strobe_chk #(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int TURN_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rd_valid,
    input logic              mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dq_out
);

    // cycles since the memory was last allowed to drive the bus
    int rel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rel <= TURN_CYC;
        end else if (!mem_cs_n && !mem_oe_n) begin
            rel <= 0;
        end else if (rel < TURN_CYC) begin
            rel <= rel + 1;
        end
    end

    p_no_drive_in_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !mem_oe_n) |-> !mem_dq_oe);

    p_turn_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rel < TURN_CYC) |-> !mem_dq_oe);

    p_oe_high_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || mem_dq_oe) |-> mem_oe_n);

    p_we_within_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cs_n);

    p_write_bus_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> ($stable(mem_addr) && $stable(mem_dq_out) && mem_dq_oe));

    p_rd_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_rd_valid_in_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!mem_cs_n && !mem_oe_n));

    p_ready_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind sram_strobe_ctrl sram_strobe_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .TURN_CYC (TURN_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_oe  (mem_dq_oe),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out)
);

// File: tb/sram_strobe_ctrl_bench.sv
module sram_strobe_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [14:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    always #10 clk = ~clk;

    sram_strobe_ctrl u_sram_strobe_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .mem_cs_n   (mem_cs_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .mem_dq_in  (mem_dq_in),
        .mem_dq_oe  (mem_dq_oe)
    );

    // memory model: 64 words keyed by the low address bits, 70 ns access
    logic [7:0] model [0:63];
    int rd_age = 0;
    int rel    = 3;
    int contention = 0;
    int oe_we_low  = 0;

    initial begin
        for (int i = 0; i < 64; i++) model[i] = 8'(i) ^ 8'h99;
    end

    assign mem_dq_in = (rd_age >= 4) ? model[mem_addr[5:0]] : 8'hEE;

    always @(negedge clk) begin
        if (!mem_cs_n && !mem_oe_n && mem_we_n) rd_age <= rd_age + 1;
        else rd_age <= 0;
        if (!mem_cs_n && !mem_we_n) model[mem_addr[5:0]] <= mem_dq_out;
        if (rst_n) begin
            if (mem_dq_oe && ((!mem_cs_n && !mem_oe_n) || rel < 2)) contention <= contention + 1;
            if (!mem_oe_n && !mem_we_n) oe_we_low <= oe_we_low + 1;
        end
        if (!mem_cs_n && !mem_oe_n) rel <= 0;
        else if (rel < 3) rel <= rel + 1;
    end

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // per-transfer observations
    int busy, cs_lo, oe_lo, we_lo, rdv_cnt, rdv_idx, addr_bad, data_bad;
    logic [7:0] rdv_data;
    bit first_ok, last_ok;

    task automatic issue(input logic wr, input logic [14:0] a, input logic [7:0] d);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        // R9: scramble the request fields while busy
        req_valid = 1'b0; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
        busy = 0; cs_lo = 0; oe_lo = 0; we_lo = 0; rdv_cnt = 0; rdv_idx = -1;
        addr_bad = 0; data_bad = 0; rdv_data = '0; last_ok = 0;
        first_ok = wr ? (mem_cs_n && mem_we_n && mem_oe_n && mem_dq_oe
                         && mem_addr == a && mem_dq_out == d)
                      : (!mem_cs_n && !mem_oe_n && mem_we_n && !mem_dq_oe && mem_addr == a);
        while (!req_ready && busy < 50) begin
            if (!mem_cs_n) cs_lo++;
            if (!mem_oe_n) oe_lo++;
            if (!mem_we_n) we_lo++;
            if (!mem_cs_n && mem_addr != a) addr_bad++;
            if (wr && mem_dq_oe && (mem_dq_out != d || mem_addr != a)) data_bad++;
            if (rd_valid) begin rdv_cnt++; rdv_idx = busy; rdv_data = rd_data; end
            last_ok = wr ? (mem_cs_n && mem_we_n && mem_dq_oe && mem_addr == a && mem_dq_out == d)
                         : (mem_cs_n && mem_oe_n && !mem_dq_oe);
            busy++;
            @(negedge clk);
        end
    endtask

    // wr, addr, wdata, expected read value
    localparam logic [31:0] VEC [0:8] = '{
        {1'b1, 15'h0000, 8'h3C, 8'h00},
        {1'b1, 15'h7FFF, 8'hA5, 8'h00},
        {1'b1, 15'h1234, 8'h5A, 8'h00},
        {1'b0, 15'h0000, 8'h00, 8'h3C},
        {1'b0, 15'h7FFF, 8'h00, 8'hA5},
        {1'b1, 15'h0000, 8'hFF, 8'h00},
        {1'b0, 15'h1234, 8'h00, 8'h5A},
        {1'b0, 15'h0000, 8'h00, 8'hFF},
        {1'b0, 15'h4015, 8'h00, 8'h8C}
    };

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R2", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        // R1: reset state, during and just after reset
        repeat (2) @(negedge clk);
        check(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rd_valid && req_ready,
              "R1", "outputs in reset", {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid, req_ready}, 6'b111001);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rd_valid && req_ready,
              "R1", "outputs after reset", {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid, req_ready}, 6'b111001);

        // R10: idle with req_valid low ignores other request inputs
        begin
            int act = 0;
            for (int k = 0; k < 6; k++) begin
                req_write = k[0]; req_addr = 15'(k * 4111); req_wdata = 8'(k * 37);
                @(negedge clk);
                if (!mem_cs_n || !mem_oe_n || !mem_we_n || mem_dq_oe || !req_ready) act++;
            end
            check(act == 0, "R10", "idle cycles with activity", act, 0);
        end

        // vector table
        for (int i = 0; i < 9; i++) begin
            logic        wr;
            logic [14:0] a;
            logic [7:0]  d, e;
            {wr, a, d, e} = VEC[i];
            issue(wr, a, d);
            if (wr) begin
                check(busy == 5, "R2", "write busy cycles", busy, 5);
                check(first_ok, "R5", "write setup cycle", first_ok, 1);
                check(we_lo == 3 && cs_lo == 3, "R5", "write pulse cycles", we_lo, 3);
                check(last_ok, "R5", "write hold cycle", last_ok, 1);
                check(data_bad == 0, "R9", "write bus changed", data_bad, 0);
                check(oe_lo == 0, "R6", "oe low in write", oe_lo, 0);
                check(rdv_cnt == 0, "R4", "rd_valid in write", rdv_cnt, 0);
            end else begin
                check(busy == 7, "R2", "read busy cycles", busy, 7);
                check(first_ok, "R3", "read first strobe cycle", first_ok, 1);
                check(cs_lo == 5 && oe_lo == 5 && we_lo == 0, "R3", "read strobe cycles", cs_lo, 5);
                check(addr_bad == 0, "R9", "read address changed", addr_bad, 0);
                check(rdv_cnt == 1 && rdv_idx == 4, "R4", "rd_valid pulse position", rdv_idx, 4);
                check(rdv_data == e, "R4", "read value", rdv_data, e);
                check(last_ok, "R7", "bus released at end", last_ok, 1);
            end
        end

        // pending write waits out the bus release after a read (R2, R7, R9)
        begin
            int k = 0;
            int rv = 0;
            logic [7:0] got = '0;
            while (!req_ready) @(negedge clk);
            req_valid = 1'b1; req_write = 1'b0; req_addr = 15'h2A6B; req_wdata = 8'h00;
            @(negedge clk);
            req_write = 1'b1; req_addr = 15'h5555; req_wdata = 8'h66;
            while (!mem_dq_oe && k < 40) begin
                if (rd_valid) begin rv++; got = rd_data; end
                k++;
                @(negedge clk);
            end
            req_valid = 1'b0;
            check(k == 8, "R7", "cycles to first drive after read", k, 8);
            check(rv == 1 && got == 8'hB2, "R4", "read under pending write", got, 8'hB2);
            check(mem_addr == 15'h5555 && mem_dq_out == 8'h66, "R9", "pending write fields", mem_addr, 15'h5555);
        end
        issue(1'b0, 15'h5555, 8'h00);
        check(rdv_data == 8'h66 && rdv_cnt == 1, "R5", "pending write stored", rdv_data, 8'h66);

        // R8: default counts seen as read strobe 5 = RD_CYC 4 + 1, write pulse 3
        issue(1'b1, 15'h0001, 8'h11);
        check(we_lo == 3, "R8", "write pulse count", we_lo, 3);
        issue(1'b0, 15'h0001, 8'h00);
        check(oe_lo == 5 && rdv_idx == 4, "R8", "read access count", rdv_idx, 4);

        repeat (3) @(negedge clk);
        check(contention == 0, "R7", "bus contention cycles", contention, 0);
        check(oe_we_low == 0, "R6", "oe and we low together", oe_we_low, 0);
        finish_run();
    end

endmodule